// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller with Line Set/Clear

This block gives a processor three 8-bit general-purpose ports (A, B and C) behind a small register interface. The interface has a chip select, a read strobe, a write strobe, a 2-bit register index and an 8-bit data bus. A configuration word makes each of A and B, and each 4-bit half of C, either a latched output or a sampled input. Every port pin has its own output-enable so that pads can be built around it.

A write to the control index does one of two things, chosen by data bit 7. When bit 7 is set, the write loads a new direction configuration and clears every output latch. When bit 7 is clear, the write is a single-line command. It drives one chosen port C line high or low and leaves all other state alone. Only plain latched or sampled operation is provided. The handshake and bidirectional settings of the configuration word are decoded as plain I/O.

Top module: `tri_port_pio`

## Requirements
- R1: After reset every pin is an input (all `*_oe_o` are 0), every output latch holds 0x00, and `rdata_o` is 0x00 while no read is active.
- R2: Register index 0 selects port A, index 1 selects port B, index 2 selects port C and index 3 is the control register. Data is written on the rising clock edge where `cs_i` and `wr_i` are both high.
- R3: A control write with bit 7 set loads the direction. A 1 in bit 4 makes port A an input, bit 1 does the same for port B, bit 3 for port C lines 7..4 and bit 0 for port C lines 3..0. A 0 in any of these bits makes the group an output. For example, 0x90 gives A as input and B and all of C as outputs.
- R4: Every control write with bit 7 set clears the latches of ports A, B and C to 0x00 in the same edge.
- R5: Reading an output port returns its latch value. Reading an input port returns the pins as sampled at the previous rising clock edge. `rdata_o` is combinational from the strobes and the index.
- R6: The two halves of port C take their directions independently. A read of port C merges the sampled upper or lower pins with the latched bits of the other half.
- R7: A control write with bit 7 clear sets (bit 0 = 1) or clears (bit 0 = 0) the one port C latch line numbered by bits 3..1. Examples: 0x09 sets line 4, 0x0E clears line 7. All other latch bits and all directions stay unchanged.
- R8: `rdata_o` is 0x00 when reading the control index and whenever `cs_i` or `rd_i` is low.
- R9: A write strobe with `cs_i` low changes no latch and no direction.
- R10: Bits 6, 5 and 2 of a direction word have no effect on any direction. For example, 0xE4 makes every pin an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
The bench walks the single-line command across port C lines that are already at the requested value and lines that are not. A decoder that used the wrong bit field, or that rewrote the whole port, would show stray bits on `pc_o`. The bench also loads a new direction word over latches that hold data; a design that kept its latches would drive stale values the moment a port turned into an output. A split configuration of port C checks that the read merges pins and latch per half, where a whole-port select would return the wrong nibble. Writes with chip select low and direction words full of don't-care bits show up a decode that ignores `cs_i` or reads the wrong bit positions.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 2;
  localparam int unsigned SELW  = $clog2(DW);
  localparam int unsigned HALF  = DW / 2;

  typedef enum logic [AW-1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  // direction-word bit positions (1 = input)
  localparam int unsigned MB_KIND = 7;
  localparam int unsigned MB_A_IN = 4;
  localparam int unsigned MB_CH_IN = 3;
  localparam int unsigned MB_B_IN = 1;
  localparam int unsigned MB_CL_IN = 0;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic ch_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_RST = '{a_in: 1'b1, b_in: 1'b1, ch_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output dir_t            dir_o,
  output logic            clr_o,
  output logic            bit_wr_o,
  output logic [SELW-1:0] bit_sel_o,
  output logic            bit_val_o
);
  logic is_dir;
  assign is_dir    = wdata_i[MB_KIND];
  assign clr_o     = wr_i & is_dir;
  assign bit_wr_o  = wr_i & ~is_dir;
  assign bit_sel_o = wdata_i[SELW:1];
  assign bit_val_o = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= DIR_RST;
    end else if (clr_o) begin
      dir_o.a_in  <= wdata_i[MB_A_IN];
      dir_o.b_in  <= wdata_i[MB_B_IN];
      dir_o.ch_in <= wdata_i[MB_CH_IN];
      dir_o.cl_in <= wdata_i[MB_CL_IN];
    end
  end
endmodule

// File: rtl/pio_port_reg.sv
module pio_port_reg #(
  parameter int unsigned W       = 8,
  parameter bit          BIT_CMD = 1'b0,
  localparam int unsigned SW     = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          bit_wr_i,
  input  logic [SW-1:0] bit_sel_i,
  input  logic          bit_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] nxt;

  generate
    if (BIT_CMD) begin : g_bit
      always_comb begin
        nxt = q_o;
        if (clr_i)         nxt = '0;
        else if (wr_i)     nxt = wdata_i;
        else if (bit_wr_i) nxt[bit_sel_i] = bit_val_i;
      end
    end else begin : g_plain
      logic unused_bit;
      assign unused_bit = bit_wr_i ^ bit_val_i ^ (^bit_sel_i);
      always_comb begin
        nxt = q_o;
        if (clr_i)     nxt = '0;
        else if (wr_i) nxt = wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/pio_in_sample.sv
module pio_in_sample #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] smp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_o <= '0;
    else         smp_o <= pins_i;
  end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam int unsigned NPORT = 3;

  reg_sel_e         sel;
  logic             wr_en, rd_en;
  logic [NPORT-1:0] port_wr;
  dir_t             dir;
  logic             clr;
  logic             bit_wr;
  logic [SELW-1:0]  bit_sel;
  logic             bit_val;
  logic [DW-1:0]    q [NPORT];
  logic [NPORT*DW-1:0] smp;
  logic [DW-1:0]    a_smp, b_smp, c_smp;
  logic [DW-1:0]    c_in_mask;

  assign sel   = reg_sel_e'(addr_i);
  assign wr_en = cs_i & wr_i;
  assign rd_en = cs_i & rd_i;

  pio_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en && sel == SEL_CTL),
    .wdata_i   (wdata_i),
    .dir_o     (dir),
    .clr_o     (clr),
    .bit_wr_o  (bit_wr),
    .bit_sel_o (bit_sel),
    .bit_val_o (bit_val)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_wr[p] = wr_en && (addr_i == AW'(p));
    pio_port_reg #(
      .W       (DW),
      .BIT_CMD (p == int'(SEL_C))
    ) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .wr_i      (port_wr[p]),
      .wdata_i   (wdata_i),
      .bit_wr_i  (bit_wr),
      .bit_sel_i (bit_sel),
      .bit_val_i (bit_val),
      .q_o       (q[p])
    );
  end

  pio_in_sample #(.W(NPORT*DW)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i ({pc_i, pb_i, pa_i}),
    .smp_o  (smp)
  );
  assign {c_smp, b_smp, a_smp} = smp;

  assign c_in_mask = {{HALF{dir.ch_in}}, {HALF{dir.cl_in}}};

  assign pa_o    = q[0];
  assign pb_o    = q[1];
  assign pc_o    = q[2];
  assign pa_oe_o = {DW{~dir.a_in}};
  assign pb_oe_o = {DW{~dir.b_in}};
  assign pc_oe_o = ~c_in_mask;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_A:   rdata_o = dir.a_in ? a_smp : q[0];
        SEL_B:   rdata_o = dir.b_in ? b_smp : q[1];
        SEL_C:   rdata_o = (c_smp & c_in_mask) | (q[2] & ~c_in_mask);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tri_port_pio_chk.sv
module tri_port_pio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [7:0] pa_o,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pb_o,
  input logic [7:0] pb_oe_o,
  input logic [7:0] pc_o,
  input logic [7:0] pc_oe_o
);
  logic ctl_wr;
  assign ctl_wr = cs_i && wr_i && addr_i == 2'd3;

  a_r4_dir_clears_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && wdata_i[7] |=> pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00);

  a_r7_one_line_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && !wdata_i[7] |=> $countones(pc_o ^ $past(pc_o)) <= 1
                              && pc_o[$past(wdata_i[3:1])] == $past(wdata_i[0]));

  a_r7_rest_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && !wdata_i[7] |=> $stable(pa_o) && $stable(pb_o) && $stable(pa_oe_o)
                              && $stable(pb_oe_o) && $stable(pc_oe_o));

  a_r8_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> rdata_o == 8'h00);

  a_r8_ctl_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && rd_i && addr_i == 2'd3 |-> rdata_o == 8'h00);

  a_r9_no_cs_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pa_oe_o)
              && $stable(pb_oe_o) && $stable(pc_oe_o));
endmodule

bind tri_port_pio tri_port_pio_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pa_o    (pa_o),
  .pa_oe_o (pa_oe_o),
  .pb_o    (pb_o),
  .pb_oe_o (pb_oe_o),
  .pc_o    (pc_o),
  .pc_oe_o (pc_oe_o)
);

// File: tb/tri_port_pio_test.sv
module tri_port_pio_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  tri_port_pio uut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value queued by the driver
  always @(negedge clk_i) begin
    if (rst_ni && cs_i && rd_i) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected read actual=%02h expected=none", rdata_o);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata_o, e);
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d, logic sel = 1'b1);
    @(posedge clk_i); #1;
    cs_i = sel; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(posedge clk_i); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1;
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    // R1 reset state
    check("R1 pa_oe", pa_oe_o, 8'h00);
    check("R1 pb_oe", pb_oe_o, 8'h00);
    check("R1 pc_oe", pc_oe_o, 8'h00);
    check("R1 latches", pa_o | pb_o | pc_o, 8'h00);
    check("R1 idle rdata", rdata_o, 8'h00);

    // R5 R2 input read of port A
    pa_i = 8'h5A;
    rd(2'd0, 8'h5A, "R5 A input pins");

    // R3 direction word 0x90
    wr(2'd3, 8'h90);
    check("R3 pa_oe", pa_oe_o, 8'h00);
    check("R3 pb_oe", pb_oe_o, 8'hFF);
    check("R3 pc_oe", pc_oe_o, 8'hFF);

    // R2 R5 output ports return latch
    wr(2'd1, 8'h3C);
    check("R2 pb_o", pb_o, 8'h3C);
    rd(2'd1, 8'h3C, "R5 B latch read");
    wr(2'd2, 8'hA5);
    check("R2 pc_o", pc_o, 8'hA5);
    rd(2'd2, 8'hA5, "R5 C latch read");
    wr(2'd0, 8'h77);
    pa_i = 8'h12;
    rd(2'd0, 8'h12, "R5 A input ignores latch");

    // R7 single-line commands
    wr(2'd3, 8'h09);
    check("R7 set line4", pc_o, 8'hB5);
    wr(2'd3, 8'h0E);
    check("R7 clear line7", pc_o, 8'h35);
    wr(2'd3, 8'h01);
    check("R7 set line0 already set", pc_o, 8'h35);
    wr(2'd3, 8'h07);
    check("R7 set line3", pc_o, 8'h3D);
    check("R7 pb_o kept", pb_o, 8'h3C);
    check("R7 pb_oe kept", pb_oe_o, 8'hFF);
    check("R7 pc_oe kept", pc_oe_o, 8'hFF);

    // R8 control read
    rd(2'd3, 8'h00, "R8 control read");

    // R9 write without chip select
    wr(2'd1, 8'hFF, 1'b0);
    check("R9 pb_o unchanged", pb_o, 8'h3C);
    wr(2'd3, 8'h9B, 1'b0);
    check("R9 pb_oe unchanged", pb_oe_o, 8'hFF);

    // R4 R6 split port C, latches cleared
    wr(2'd3, 8'h88);
    check("R4 pb_o cleared", pb_o, 8'h00);
    check("R4 pc_o cleared", pc_o, 8'h00);
    check("R4 pa_o cleared", pa_o, 8'h00);
    check("R6 pc_oe split", pc_oe_o, 8'h0F);
    check("R3 pa_oe output", pa_oe_o, 8'hFF);
    wr(2'd2, 8'hFF);
    pc_i = 8'h60;
    rd(2'd2, 8'h6F, "R6 C merged read");
    wr(2'd3, 8'h81);
    pc_i = 8'hC3;
    wr(2'd2, 8'h5A);
    rd(2'd2, 8'h53, "R6 C lower input merge");

    // R10 don't-care bits
    wr(2'd3, 8'hE4);
    check("R10 pa_oe", pa_oe_o, 8'hFF);
    check("R10 pb_oe", pb_oe_o, 8'hFF);
    check("R10 pc_oe", pc_oe_o, 8'hFF);

    // R8 read strobe without chip select
    @(posedge clk_i); #1;
    rd_i = 1'b1; addr_i = 2'd1;
    #5 check("R8 rd without cs", rdata_o, 8'h00);
    rd_i = 1'b0;

    repeat (2) @(posedge clk_i);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R5 pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule